// File: doc/BRIEF.md
# Event Timer Register Front-End and Main Counter

This block is the register front-end of a multi-channel event timer. A host reaches it with single-cycle 32-bit reads and writes on a small address space. The block holds three things: a read-only identification word, a read-only word giving the counter tick period, and a global configuration word. The configuration word has a run bit and a legacy-routing bit. The block also owns the free-running 64-bit main counter. The host reads and writes that counter as two separate 32-bit words.

The main counter advances by one on every clock while the run bit is set. When the run bit is cleared, the counter holds its value and the block pulses a stop request to every channel. When the run bit is set again, counting continues from the held value. The block writes nothing itself for the channels. Addresses from 0x100 upward are split into 0x20-byte windows, one per channel. For each access in a window the block produces a one-hot read or write strobe, together with the register offset inside the window. Channel read data comes back through a flat input bus. The current count is also driven out so that the channel comparators can use it.

Top module: `etimer_regs`

## Requirements
- R1: After reset, address 0x000 reads the identification word (default 0x8086A201), address 0x004 reads the tick period parameter, and the configuration word and both counter words read zero.
- R2: Address 0x010 is the configuration word: bit 0 is the run bit (driven on `timerEn`), bit 1 is legacy routing (driven on `legacyRoute`), and every other bit reads zero. Address 0x014 always reads zero, and writes to it change nothing.
- R3: While the run bit is set and no bus write occurs, the main counter rises by exactly one per clock.
- R4: A write that changes the run bit from 1 to 0 freezes the counter from the next cycle on. It also raises `haltAll` for exactly one cycle, in the cycle after the write. A write that leaves the run bit at 0 raises no `haltAll`.
- R5: After the run bit is set again, the counter continues from the frozen value, one count per clock.
- R6: A write to address 0x0F0 replaces counter bits 31:0 and leaves bits 63:32 unchanged. A read of 0x0F0 returns bits 31:0.
- R7: A write to address 0x0F4 replaces counter bits 63:32 and leaves bits 31:0 unchanged. A read of 0x0F4 returns bits 63:32.
- R8: A counter write performed while the run bit is set takes effect. It raises `cntWrBusy` for one cycle, in the cycle after the write. A counter write while stopped leaves `cntWrBusy` low.
- R9: An access at address A, where 0x100 <= A < 0x100 + NUM_CHAN*0x20, selects channel (A-0x100)/0x20. That channel's bit alone rises on `chanWrStb` for a write, or on `chanRdStb` for a read. `chanReg` carries (A-0x100) mod 0x20, and a read returns that channel's 32-bit slice of `chanRdData` (channel n at bits 32n+31:32n).
- R10: Writes to 0x000 and 0x004 are ignored. Any address that is not decoded reads zero and raises no channel strobe.
- R11: A carry out of counter bit 31 propagates into bit 32 while counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWr | input | 1 | Write request, one cycle per access |
| busRd | input | 1 | Read request, one cycle per access |
| busAddr | input | ADDR_W | Byte address, word aligned |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, combinational from address |
| chanRdData | input | NUM_CHAN*32 | Read data from each channel, concatenated |
| chanWrStb | output | NUM_CHAN | One-hot channel write strobe |
| chanRdStb | output | NUM_CHAN | One-hot channel read strobe |
| chanReg | output | 5 | Offset inside the selected channel window |
| mainCount | output | 64 | Current main counter value |
| timerEn | output | 1 | Run bit |
| legacyRoute | output | 1 | Legacy routing bit |
| haltAll | output | 1 | One-cycle stop request to all channels |
| cntWrBusy | output | 1 | One-cycle flag: counter written while running |

## Verification
The assertions assume that `busWr` and `busRd` are never high in the same cycle. They also assume that every address is word aligned. The counter-step and freeze properties are checked only in cycles with no bus write, since a write can legitimately move the counter. The bench drives one access at a time, at the falling edge, always on aligned addresses. It leaves idle cycles between accesses so that each counting interval is free of writes.

// File: rtl/etimer_pkg.sv
package etimer_pkg;

  localparam logic [11:0] OFS_ID     = 12'h000;
  localparam logic [11:0] OFS_PERIOD = 12'h004;
  localparam logic [11:0] OFS_CFG    = 12'h010;
  localparam logic [11:0] OFS_CFGHI  = 12'h014;
  localparam logic [11:0] OFS_CNTLO  = 12'h0F0;
  localparam logic [11:0] OFS_CNTHI  = 12'h0F4;
  localparam int          CHAN_BASE   = 'h100;
  localparam int          CHAN_STRIDE = 'h20;

  typedef enum logic [2:0] {
    RS_NONE, RS_ID, RS_PERIOD, RS_CFG, RS_CNTLO, RS_CNTHI, RS_CHAN
  } rdSel_e;

  // Strobes from decode to datapath
  typedef struct packed {
    logic   wrCfg;
    logic   wrCntLo;
    logic   wrCntHi;
    rdSel_e rdSel;
  } ctrlStb_t;

endpackage

// File: rtl/etimer_ctrl.sv
module etimer_ctrl
  import etimer_pkg::*;
#(
  parameter int NUM_CHAN = 3,
  parameter int ADDR_W   = 12,
  localparam int IDX_W   = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                busWr,
  input  logic                busRd,
  input  logic [ADDR_W-1:0]   busAddr,
  output ctrlStb_t            stb,
  output logic [IDX_W-1:0]    chanIdx,
  output logic [4:0]          chanReg,
  output logic [NUM_CHAN-1:0] chanWrStb,
  output logic [NUM_CHAN-1:0] chanRdStb
);

  localparam int CHAN_SPAN = NUM_CHAN * CHAN_STRIDE;

  logic [ADDR_W-1:0] relAddr;
  logic              inChan;

  assign relAddr = busAddr - ADDR_W'(CHAN_BASE);
  assign inChan  = (busAddr >= ADDR_W'(CHAN_BASE)) && (relAddr < ADDR_W'(CHAN_SPAN));
  assign chanIdx = IDX_W'(relAddr >> 5);
  assign chanReg = relAddr[4:0];

  always_comb begin
    stb = '{wrCfg: 1'b0, wrCntLo: 1'b0, wrCntHi: 1'b0, rdSel: RS_NONE};
    if (inChan) begin
      stb.rdSel = RS_CHAN;
    end else begin
      case (busAddr)
        ADDR_W'(OFS_ID):     stb.rdSel = RS_ID;
        ADDR_W'(OFS_PERIOD): stb.rdSel = RS_PERIOD;
        ADDR_W'(OFS_CFG): begin
          stb.rdSel = RS_CFG;
          stb.wrCfg = busWr;
        end
        ADDR_W'(OFS_CNTLO): begin
          stb.rdSel   = RS_CNTLO;
          stb.wrCntLo = busWr;
        end
        ADDR_W'(OFS_CNTHI): begin
          stb.rdSel   = RS_CNTHI;
          stb.wrCntHi = busWr;
        end
        default: stb.rdSel = RS_NONE;
      endcase
    end
  end

  for (genvar g = 0; g < NUM_CHAN; g++) begin : g_stb
    logic hit;
    assign hit          = inChan && (chanIdx == IDX_W'(g));
    assign chanWrStb[g] = hit && busWr;
    assign chanRdStb[g] = hit && busRd;
  end

endmodule

// File: rtl/etimer_dpath.sv
module etimer_dpath
  import etimer_pkg::*;
#(
  parameter int          NUM_CHAN  = 3,
  parameter logic [31:0] ID_WORD   = 32'h8086A201,
  parameter logic [31:0] TICK_FS   = 32'h0098_9680,
  localparam int         IDX_W     = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctrlStb_t               stb,
  input  logic [IDX_W-1:0]       chanIdx,
  input  logic [31:0]            busWrData,
  input  logic [NUM_CHAN*32-1:0] chanRdData,
  output logic [31:0]            busRdData,
  output logic [63:0]            mainCount,
  output logic                   timerEn,
  output logic                   legacyRoute,
  output logic                   haltAll,
  output logic                   cntWrBusy
);

  logic [63:0] countQ;
  logic        runQ, legacyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      countQ    <= '0;
      runQ      <= 1'b0;
      legacyQ   <= 1'b0;
      haltAll   <= 1'b0;
      cntWrBusy <= 1'b0;
    end else begin
      // a 1->0 change of the run bit is seen by comparing old and new
      haltAll   <= stb.wrCfg && runQ && !busWrData[0];
      cntWrBusy <= (stb.wrCntLo || stb.wrCntHi) && runQ;
      if (stb.wrCfg) begin
        runQ    <= busWrData[0];
        legacyQ <= busWrData[1];
      end
      if (stb.wrCntLo)      countQ <= {countQ[63:32], busWrData};
      else if (stb.wrCntHi) countQ <= {busWrData, countQ[31:0]};
      else if (runQ)        countQ <= countQ + 64'd1;
    end
  end

  always_comb begin
    case (stb.rdSel)
      RS_ID:     busRdData = ID_WORD;
      RS_PERIOD: busRdData = TICK_FS;
      RS_CFG:    busRdData = {30'd0, legacyQ, runQ};
      RS_CNTLO:  busRdData = countQ[31:0];
      RS_CNTHI:  busRdData = countQ[63:32];
      RS_CHAN:   busRdData = chanRdData[32*int'(chanIdx) +: 32];
      default:   busRdData = '0;
    endcase
  end

  assign mainCount   = countQ;
  assign timerEn     = runQ;
  assign legacyRoute = legacyQ;

endmodule

// File: rtl/etimer_regs.sv
module etimer_regs
  import etimer_pkg::*;
#(
  parameter int          NUM_CHAN = 3,
  parameter int          ADDR_W   = 12,
  parameter logic [31:0] ID_WORD  = 32'h8086A201,
  parameter logic [31:0] TICK_FS  = 32'h0098_9680
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   busWr,
  input  logic                   busRd,
  input  logic [ADDR_W-1:0]      busAddr,
  input  logic [31:0]            busWrData,
  output logic [31:0]            busRdData,
  input  logic [NUM_CHAN*32-1:0] chanRdData,
  output logic [NUM_CHAN-1:0]    chanWrStb,
  output logic [NUM_CHAN-1:0]    chanRdStb,
  output logic [4:0]             chanReg,
  output logic [63:0]            mainCount,
  output logic                   timerEn,
  output logic                   legacyRoute,
  output logic                   haltAll,
  output logic                   cntWrBusy
);

  localparam int IDX_W = (NUM_CHAN > 1) ? $clog2(NUM_CHAN) : 1;

  ctrlStb_t         stb;
  logic [IDX_W-1:0] chanIdx;

  etimer_ctrl #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) i_ctrl (
    .busWr(busWr), .busRd(busRd), .busAddr(busAddr),
    .stb(stb), .chanIdx(chanIdx), .chanReg(chanReg),
    .chanWrStb(chanWrStb), .chanRdStb(chanRdStb)
  );

  etimer_dpath #(.NUM_CHAN(NUM_CHAN), .ID_WORD(ID_WORD), .TICK_FS(TICK_FS)) i_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .chanIdx(chanIdx),
    .busWrData(busWrData), .chanRdData(chanRdData), .busRdData(busRdData),
    .mainCount(mainCount), .timerEn(timerEn), .legacyRoute(legacyRoute),
    .haltAll(haltAll), .cntWrBusy(cntWrBusy)
  );

endmodule

// File: rtl/etimer_regs_chk.sv
module etimer_regs_chk #(
  parameter int NUM_CHAN = 3,
  parameter int ADDR_W   = 12
) (
  input logic                clk,
  input logic                rstN,
  input logic                busWr,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [31:0]         busWrData,
  input logic [63:0]         mainCount,
  input logic                timerEn,
  input logic                haltAll,
  input logic                cntWrBusy,
  input logic [NUM_CHAN-1:0] chanWrStb,
  input logic [NUM_CHAN-1:0] chanRdStb
);

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    timerEn && !busWr |=> mainCount == $past(mainCount) + 64'd1);

  p_freeze_r4: assert property (@(posedge clk) disable iff (!rstN)
    !timerEn && !busWr |=> $stable(mainCount));

  p_halt_r4: assert property (@(posedge clk) disable iff (!rstN)
    haltAll |-> !timerEn && $past(timerEn));

  p_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    cntWrBusy |-> $past(timerEn));

  p_wrlo_r6: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_W'('h0F0) |=> mainCount[31:0] == $past(busWrData));

  p_wrhi_r7: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_W'('h0F4) |=> mainCount[63:32] == $past(busWrData));

  p_onehot_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(chanWrStb) && $onehot0(chanRdStb));

endmodule

bind etimer_regs etimer_regs_chk #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) i_chk (.*);

// File: tb/test_etimer_regs.sv
module test_etimer_regs;

  localparam int NUM_CHAN = 3;
  localparam int ADDR_W   = 12;
  localparam logic [31:0] ID_W = 32'h8086A201;
  localparam logic [31:0] PER  = 32'h0098_9680;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;
  logic [NUM_CHAN*32-1:0] chanRdData;
  logic [NUM_CHAN-1:0] chanWrStb, chanRdStb;
  logic [4:0] chanReg;
  logic [63:0] mainCount;
  logic timerEn, legacyRoute, haltAll, cntWrBusy;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  assign chanRdData = {32'hC2C2_0002, 32'hC1C1_0001, 32'hC0C0_0000};

  etimer_regs #(.NUM_CHAN(NUM_CHAN), .ADDR_W(ADDR_W)) i_etimer_regs (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWr = 1'b1;
    @(posedge clk);
    #1 busWr = 1'b0;
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    #1 d = busRdData;
    busRd = 1'b0;
  endtask

  task automatic setCount(input logic [63:0] v);
    busWrite(12'h0F4, v[63:32]);
    busWrite(12'h0F0, v[31:0]);
  endtask

  task automatic testReset();
    logic [31:0] d;
    busRead(12'h000, d); chk("R1 id", d, ID_W);
    busRead(12'h004, d); chk("R1 period", d, PER);
    busRead(12'h010, d); chk("R1 cfg", d, 0);
    busRead(12'h0F0, d); chk("R1 cnt lo", d, 0);
    busRead(12'h0F4, d); chk("R1 cnt hi", d, 0);
  endtask

  task automatic testConfig();
    logic [31:0] d;
    busWrite(12'h010, 32'hFFFF_FFFE);
    busRead(12'h010, d); chk("R2 cfg bits", d, 32'h2);
    chk("R2 legacy pin", legacyRoute, 1);
    chk("R2 run pin", timerEn, 0);
    chk("R4 no halt on 0->0", haltAll, 0);
    busWrite(12'h014, 32'hFFFF_FFFF);
    busRead(12'h014, d); chk("R2 cfg hi zero", d, 0);
    busRead(12'h010, d); chk("R2 cfg hi ignored", d, 32'h2);
    busWrite(12'h000, 32'h0);
    busWrite(12'h004, 32'h0);
    busRead(12'h000, d); chk("R10 id ro", d, ID_W);
    busRead(12'h004, d); chk("R10 period ro", d, PER);
    busRead(12'h0FC, d); chk("R10 undecoded", d, 0);
    busWrite(12'h010, 32'h0);
  endtask

  task automatic testHalves();
    logic [31:0] d;
    busWrite(12'h0F4, 32'h1234_5678);
    busWrite(12'h0F0, 32'h9ABC_DEF0);
    chk("R6 R7 full", mainCount, 64'h1234_5678_9ABC_DEF0);
    chk("R8 no busy when stopped", cntWrBusy, 0);
    busWrite(12'h0F0, 32'h1);
    chk("R6 hi kept", mainCount, 64'h1234_5678_0000_0001);
    busWrite(12'h0F4, 32'hA5A5_A5A5);
    chk("R7 lo kept", mainCount, 64'hA5A5_A5A5_0000_0001);
    busRead(12'h0F4, d); chk("R7 read hi", d, 32'hA5A5_A5A5);
    busRead(12'h0F0, d); chk("R6 read lo", d, 32'h1);
  endtask

  task automatic testRunFreeze();
    logic [63:0] held;
    setCount(64'h10);
    busWrite(12'h010, 32'h1);
    repeat (7) @(posedge clk);
    #1 chk("R3 seven steps", mainCount, 64'h17);
    busWrite(12'h010, 32'h0);
    chk("R4 halt pulse", haltAll, 1);
    held = mainCount;
    @(posedge clk); #1 chk("R4 halt one cycle", haltAll, 0);
    repeat (10) @(posedge clk);
    #1 chk("R4 frozen", mainCount, held);
    busWrite(12'h010, 32'h1);
    repeat (4) @(posedge clk);
    #1 chk("R5 resume", mainCount, held + 64'd4);
    busWrite(12'h010, 32'h0);
  endtask

  task automatic testCarry();
    setCount(64'h5_FFFF_FFFE);
    busWrite(12'h010, 32'h1);
    repeat (3) @(posedge clk);
    #1 chk("R11 carry", mainCount, 64'h6_0000_0001);
    busWrite(12'h0F4, 32'h0000_0ABC);
    chk("R8 write while running", mainCount[63:32], 64'hABC);
    chk("R8 busy pulse", cntWrBusy, 1);
    @(posedge clk); #1 chk("R8 busy one cycle", cntWrBusy, 0);
    busWrite(12'h010, 32'h0);
  endtask

  task automatic testChannels();
    logic [31:0] d;
    @(negedge clk);
    busAddr = 12'h128; busRd = 1'b1;
    #1 chk("R9 rd strobe", chanRdStb, 3'b010);
    chk("R9 reg ofs", chanReg, 5'h08);
    chk("R9 rd data", busRdData, 32'hC1C1_0001);
    busRd = 1'b0;
    @(negedge clk);
    busAddr = 12'h14C; busWrData = 32'h1; busWr = 1'b1;
    #1 chk("R9 wr strobe", chanWrStb, 3'b100);
    chk("R9 wr reg ofs", chanReg, 5'h0C);
    @(posedge clk); #1 busWr = 1'b0;
    busRead(12'h100, d); chk("R9 chan0 data", d, 32'hC0C0_0000);
    @(negedge clk);
    busAddr = 12'h160; busWr = 1'b1;
    #1 chk("R10 beyond channels no strobe", chanWrStb, 0);
    @(posedge clk); #1 busWr = 1'b0;
    busRead(12'h160, d); chk("R10 beyond channels read", d, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testConfig();
    testHalves();
    testRunFreeze();
    testCarry();
    testChannels();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule